// File: doc/BRIEF.md
# Cyclic Process-Image Register Access Handler

This block sits behind a fieldbus gateway and takes one 8-byte output telegram per bus cycle. From each telegram it derives a stop request for the serial encoder reader, the enable and clear controls for two position comparators, and an indirect access to a bank of 32-bit registers. The bank has a 64-address space, and only its lower part is implemented. The result of the read is returned in the fields of the next response telegram, together with an abort flag and a write acknowledge.

The telegram arrives as eight bytes on a 64-bit bus and is taken in whole when a valid strobe is high. A static ordering input chooses between two fieldbus conventions. In one convention logical byte k sits at wire offset k. In the other it sits at offset 7-k. The decoded controls and the response fields change on the clock edge after the capture edge.

The comparator release, status and flag results come in from an external comparison stage. For each comparator, the block passes these results through only while that comparator is enabled.

Top module: `procimg_reg_access`

## Requirements
- R1: `tlg_data` is captured only on a rising clock edge where `tlg_valid` is 1. Decoded outputs and response fields change on the next rising edge after that. Without a strobe, all registered outputs keep their values.
- R2: With `order_rev`=0, logical byte k is taken from `tlg_data[8k+7:8k]`. With `order_rev`=1, it is taken from `tlg_data[8(7-k)+7:8(7-k)]`.
- R3: `enc_stop` equals bit 7 of logical byte 0. A 1 asks the reader to halt encoder traffic and a 0 asks for cyclic reads. Bits 6..0 of byte 0 are ignored.
- R4: In logical byte 1, bit 0 drives `cmp_en[0]`, bit 1 drives `cmp_clr[0]`, bit 3 drives `cmp_en[1]` and bit 4 drives `cmp_clr[1]`. Bits 2, 5, 6 and 7 are ignored.
- R5: While `cmp_en[x]` is 0, `cmp_rel[x]`, `cmp_sts[x]` and `cmp_flag[x]` are 0. While it is 1, they equal the matching raw inputs.
- R6: Logical byte 2 holds a write request in bit 7 and the write address in bits 5..0. Bytes 4..7 hold the write data, least significant byte first. A write takes place only when the request is 1 and the previously processed telegram had a request of 0, so a held request writes once.
- R7: After a telegram is processed, `rsp_wr_ack` equals the write request bit of that telegram.
- R8: Logical byte 3 bits 5..0 select the register to read, and bits 7..6 are ignored. `rsp_rd_data` returns the register contents as they stood before any write carried by the same telegram.
- R9: Addresses at or above NUM_REGS (default 16) are not implemented. A read there sets `rsp_rd_abort`=1 with `rsp_rd_data`=0, and a write there changes no register. A read of an implemented address gives an abort of 0.
- R10: Synchronous reset clears `enc_stop`, `cmp_en`, `cmp_clr`, the response fields, the write-request history and every register to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| order_rev | input | 1 | Byte ordering select: 0 direct, 1 reversed |
| tlg_valid | input | 1 | Telegram strobe |
| tlg_data | input | 64 | Output telegram, wire offset j at bits 8j+7..8j |
| cmp_rel_raw | input | 2 | Raw release results per comparator |
| cmp_sts_raw | input | 2 | Raw status results per comparator |
| cmp_flag_raw | input | 2 | Raw flag results per comparator |
| enc_stop | output | 1 | Stop request to encoder reader |
| cmp_en | output | 2 | Comparator enables |
| cmp_clr | output | 2 | Comparator clear controls |
| cmp_rel | output | 2 | Gated release results |
| cmp_sts | output | 2 | Gated status results |
| cmp_flag | output | 2 | Gated flag results |
| rsp_rd_data | output | 32 | Read data for the response telegram |
| rsp_rd_abort | output | 1 | Read aborted (address not implemented) |
| rsp_wr_ack | output | 1 | Write request echo |

## Verification
The bench builds the block with the default NUM_REGS of 16. Under that setting, most of the 6-bit address space (16 to 63) is unimplemented, so the bench can reach aborting reads and ignored writes as well as the boundary pair 15 and 16. Both byte orderings are exercised with asymmetric data words, so a swapped byte shows up in the read-back.

// File: rtl/procimg_pkg.sv
package procimg_pkg;
    localparam int TLG_BYTES = 8;
    localparam int TLG_W     = 8 * TLG_BYTES;
    localparam int ADDR_W    = 6;
    localparam int DATA_W    = 32;
    localparam int CMP_N     = 2;
    localparam int CMP_STRIDE = 3;

    typedef struct packed {
        logic              stop;
        logic [CMP_N-1:0]  cmp_en;
        logic [CMP_N-1:0]  cmp_clr;
        logic              wr_req;
        logic [ADDR_W-1:0] wr_addr;
        logic [ADDR_W-1:0] rd_addr;
        logic [DATA_W-1:0] wr_data;
    } tlg_fields_t;

    typedef struct packed {
        logic              valid;
        tlg_fields_t       tlg;
        logic              prev_req;
        logic              stop;
        logic [CMP_N-1:0]  en;
        logic [CMP_N-1:0]  clr;
        logic [DATA_W-1:0] rd_data;
        logic              rd_abort;
        logic              wr_ack;
    } hdl_state_t;
endpackage

// File: rtl/procimg_byteorder.sv
module procimg_byteorder #(
    parameter int NBYTES = 8
) (
    input  logic                  swap,
    input  logic [8*NBYTES-1:0]   wire_bytes,
    output logic [8*NBYTES-1:0]   ord_bytes
);
    // Logical byte k comes from wire offset k, or from offset NBYTES-1-k when swapped.
    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        assign ord_bytes[8*k +: 8] = swap ? wire_bytes[8*(NBYTES-1-k) +: 8]
                                          : wire_bytes[8*k +: 8];
    end
endmodule

// File: rtl/procimg_field_decode.sv
module procimg_field_decode
    import procimg_pkg::*;
(
    input  logic [TLG_W-1:0] tbytes,
    output tlg_fields_t      fields
);
    localparam int B_STOP = 0;
    localparam int B_CMP  = 1;
    localparam int B_WCTL = 2;
    localparam int B_RADR = 3;
    localparam int B_DATA = 4;

    always_comb begin
        fields.stop = tbytes[8*B_STOP + 7];
        for (int i = 0; i < CMP_N; i++) begin
            fields.cmp_en[i]  = tbytes[8*B_CMP + CMP_STRIDE*i];
            fields.cmp_clr[i] = tbytes[8*B_CMP + CMP_STRIDE*i + 1];
        end
        fields.wr_req  = tbytes[8*B_WCTL + 7];
        fields.wr_addr = tbytes[8*B_WCTL +: ADDR_W];
        fields.rd_addr = tbytes[8*B_RADR +: ADDR_W];
        fields.wr_data = tbytes[8*B_DATA +: DATA_W];
    end

    // Spare bits of the control bytes carry no meaning.
    logic unused_spare;
    assign unused_spare = ^{tbytes[8*B_STOP +: 7], tbytes[8*B_CMP + 2],
                            tbytes[8*B_CMP + 5 +: 3], tbytes[8*B_WCTL + 6],
                            tbytes[8*B_RADR + 6 +: 2]};
endmodule

// File: rtl/procimg_regbank.sv
module procimg_regbank #(
    parameter int NUM_REGS = 16,
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_hit
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_REGS);

    logic [DATA_W-1:0] regs_q [NUM_REGS];
    logic [DATA_W-1:0] regs_d [NUM_REGS];
    logic              wr_hit;

    assign wr_hit = ({1'b0, wr_addr} < LIMIT);
    assign rd_hit = ({1'b0, rd_addr} < LIMIT);

    always_comb begin
        regs_d = regs_q;
        if (wr_en && wr_hit) begin
            regs_d[wr_addr[IDX_W-1:0]] = wr_data;
        end
        rd_data = rd_hit ? regs_q[rd_addr[IDX_W-1:0]] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end
endmodule

// File: rtl/procimg_cmpgate.sv
module procimg_cmpgate #(
    parameter int N = 2
) (
    input  logic [N-1:0] en,
    input  logic [N-1:0] rel_raw,
    input  logic [N-1:0] sts_raw,
    input  logic [N-1:0] flag_raw,
    output logic [N-1:0] rel,
    output logic [N-1:0] sts,
    output logic [N-1:0] flag
);
    for (genvar x = 0; x < N; x++) begin : g_cmp
        assign rel[x]  = en[x] & rel_raw[x];
        assign sts[x]  = en[x] & sts_raw[x];
        assign flag[x] = en[x] & flag_raw[x];
    end
endmodule

// File: rtl/procimg_reg_access.sv
module procimg_reg_access
    import procimg_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        order_rev,
    input  logic        tlg_valid,
    input  logic [63:0] tlg_data,
    input  logic [1:0]  cmp_rel_raw,
    input  logic [1:0]  cmp_sts_raw,
    input  logic [1:0]  cmp_flag_raw,
    output logic        enc_stop,
    output logic [1:0]  cmp_en,
    output logic [1:0]  cmp_clr,
    output logic [1:0]  cmp_rel,
    output logic [1:0]  cmp_sts,
    output logic [1:0]  cmp_flag,
    output logic [31:0] rsp_rd_data,
    output logic        rsp_rd_abort,
    output logic        rsp_wr_ack
);
    logic [TLG_W-1:0]  ord_bytes;
    tlg_fields_t       dec_fields;
    hdl_state_t        st_d, st_q;
    logic              wr_en;
    logic [DATA_W-1:0] bank_rd_data;
    logic              bank_rd_hit;

    procimg_byteorder #(.NBYTES(TLG_BYTES)) u_order (
        .swap       (order_rev),
        .wire_bytes (tlg_data),
        .ord_bytes  (ord_bytes)
    );

    procimg_field_decode u_decode (
        .tbytes (ord_bytes),
        .fields (dec_fields)
    );

    // Edge-triggered write: only a 0->1 change of the request across processed telegrams.
    assign wr_en = st_q.valid && st_q.tlg.wr_req && !st_q.prev_req;

    procimg_regbank #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (st_q.tlg.wr_addr),
        .wr_data (st_q.tlg.wr_data),
        .rd_addr (st_q.tlg.rd_addr),
        .rd_data (bank_rd_data),
        .rd_hit  (bank_rd_hit)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = tlg_valid;
        if (tlg_valid) begin
            st_d.tlg = dec_fields;
        end
        if (st_q.valid) begin
            st_d.stop     = st_q.tlg.stop;
            st_d.en       = st_q.tlg.cmp_en;
            st_d.clr      = st_q.tlg.cmp_clr;
            st_d.rd_data  = bank_rd_hit ? bank_rd_data : '0;
            st_d.rd_abort = !bank_rd_hit;
            st_d.wr_ack   = st_q.tlg.wr_req;
            st_d.prev_req = st_q.tlg.wr_req;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign enc_stop     = st_q.stop;
    assign cmp_en       = st_q.en;
    assign cmp_clr      = st_q.clr;
    assign rsp_rd_data  = st_q.rd_data;
    assign rsp_rd_abort = st_q.rd_abort;
    assign rsp_wr_ack   = st_q.wr_ack;

    procimg_cmpgate #(.N(CMP_N)) u_gate (
        .en       (st_q.en),
        .rel_raw  (cmp_rel_raw),
        .sts_raw  (cmp_sts_raw),
        .flag_raw (cmp_flag_raw),
        .rel      (cmp_rel),
        .sts      (cmp_sts),
        .flag     (cmp_flag)
    );

    // R9: aborted reads never carry data
    a_r9_abort_zero_data: assert property (@(posedge clk) disable iff (rst)
        rsp_rd_abort |-> (rsp_rd_data == '0));

    // R1: without a captured telegram the registered outputs hold
    a_r1_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
        !st_q.valid |=> ($stable(enc_stop) && $stable(cmp_en) && $stable(cmp_clr)
                         && $stable(rsp_rd_data) && $stable(rsp_wr_ack)));

    // R6: a bank write is always preceded by a strobe
    a_r6_write_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(tlg_valid));

    // R7: acknowledge only rises when a telegram was being processed
    a_r7_ack_from_telegram: assert property (@(posedge clk) disable iff (rst)
        $rose(rsp_wr_ack) |-> $past(st_q.valid));

    // R10: the cycle after reset shows cleared controls
    a_r10_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (!enc_stop && cmp_en == '0 && cmp_clr == '0 && !rsp_wr_ack
                        && rsp_rd_data == '0 && !rsp_rd_abort));

    // R5: disabled comparators report nothing
    for (genvar x = 0; x < CMP_N; x++) begin : g_gate_chk
        a_r5_gate_disabled: assert property (@(posedge clk) disable iff (rst)
            !cmp_en[x] |-> (!cmp_rel[x] && !cmp_sts[x] && !cmp_flag[x]));
    end
endmodule

// File: tb/procimg_reg_access_test.sv
module procimg_reg_access_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        order_rev = 1'b0;
    logic        tlg_valid = 1'b0;
    logic [63:0] tlg_data = '0;
    logic [1:0]  cmp_rel_raw = '0, cmp_sts_raw = '0, cmp_flag_raw = '0;
    logic        enc_stop, rsp_rd_abort, rsp_wr_ack;
    logic [1:0]  cmp_en, cmp_clr, cmp_rel, cmp_sts, cmp_flag;
    logic [31:0] rsp_rd_data;

    always #5 clk = ~clk;

    procimg_reg_access #(.NUM_REGS(16)) uut (
        .clk(clk), .rst(rst), .order_rev(order_rev), .tlg_valid(tlg_valid),
        .tlg_data(tlg_data), .cmp_rel_raw(cmp_rel_raw), .cmp_sts_raw(cmp_sts_raw),
        .cmp_flag_raw(cmp_flag_raw), .enc_stop(enc_stop), .cmp_en(cmp_en),
        .cmp_clr(cmp_clr), .cmp_rel(cmp_rel), .cmp_sts(cmp_sts), .cmp_flag(cmp_flag),
        .rsp_rd_data(rsp_rd_data), .rsp_rd_abort(rsp_rd_abort), .rsp_wr_ack(rsp_wr_ack)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit mon_on  = 1'b0;

    // Behavioural reference state
    logic [31:0] mregs [0:63];
    bit          m_prev = 0;
    logic        e_stop = 0, e_abort = 0, e_ack = 0;
    logic [1:0]  e_en = 0, e_clr = 0;
    logic [31:0] e_rd = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            chk("R3 enc_stop", {31'b0, enc_stop}, {31'b0, e_stop});
            chk("R4 cmp_en", {30'b0, cmp_en}, {30'b0, e_en});
            chk("R4 cmp_clr", {30'b0, cmp_clr}, {30'b0, e_clr});
            chk("R5 cmp_rel", {30'b0, cmp_rel}, {30'b0, e_en & cmp_rel_raw});
            chk("R5 cmp_sts", {30'b0, cmp_sts}, {30'b0, e_en & cmp_sts_raw});
            chk("R5 cmp_flag", {30'b0, cmp_flag}, {30'b0, e_en & cmp_flag_raw});
            chk("R8 rsp_rd_data", rsp_rd_data, e_rd);
            chk("R9 rsp_rd_abort", {31'b0, rsp_rd_abort}, {31'b0, e_abort});
            chk("R7 rsp_wr_ack", {31'b0, rsp_wr_ack}, {31'b0, e_ack});
        end
    end

    task automatic model_clear();
        for (int i = 0; i < 64; i++) mregs[i] = '0;
        m_prev = 0; e_stop = 0; e_abort = 0; e_ack = 0; e_en = 0; e_clr = 0; e_rd = 0;
    endtask

    task automatic do_reset();
        mon_on = 1'b0;
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); @(posedge clk); #1 rst = 1'b0;
        model_clear();
        @(negedge clk);
        // R10: every registered output zero straight after reset
        chk("R10 reset outputs", {enc_stop, cmp_en, cmp_clr, rsp_rd_abort, rsp_wr_ack},
            32'h0);
        chk("R10 reset rd_data", rsp_rd_data, 32'h0);
        mon_on = 1'b1;
    endtask

    task automatic send(bit rev, bit stop, logic [7:0] cmpb, bit wreq, logic [5:0] waddr,
                        logic [5:0] raddr, logic [31:0] wdata);
        logic [7:0] b [8];
        bit hit;
        b[0] = {stop, 7'h2A};
        b[1] = cmpb;
        b[2] = {wreq, 1'b1, waddr};
        b[3] = {2'b11, raddr};
        for (int k = 0; k < 4; k++) b[4+k] = wdata[8*k +: 8];
        @(posedge clk); #1;
        order_rev = rev;
        for (int k = 0; k < 8; k++) begin
            if (rev) tlg_data[8*(7-k) +: 8] = b[k];
            else     tlg_data[8*k +: 8]     = b[k];
        end
        tlg_valid = 1'b1;
        @(posedge clk); #1;
        tlg_valid = 1'b0;
        tlg_data  = 64'hF0E1_D2C3_B4A5_9687;
        @(posedge clk); #1;
        hit     = (raddr < 16);
        e_rd    = hit ? mregs[raddr] : 32'h0;
        e_abort = !hit;
        if (wreq && !m_prev && hit == hit && waddr < 16) mregs[waddr] = wdata;
        m_prev  = wreq;
        e_ack   = wreq;
        e_stop  = stop;
        e_en    = {cmpb[3], cmpb[0]};
        e_clr   = {cmpb[4], cmpb[1]};
    endtask

    initial begin
        model_clear();
        do_reset();

        // R3 R4 R6 R7: write reg 3, read of same reg shows pre-write contents (R8)
        send(0, 1, 8'h1B, 1, 6'd3, 6'd3, 32'h1122_3344);
        @(negedge clk);
        chk("R8 read-before-write", rsp_rd_data, 32'h0);
        chk("R7 ack set", {31'b0, rsp_wr_ack}, 32'h1);

        // R6: request held high must not rewrite
        send(0, 0, 8'h09, 1, 6'd3, 6'd3, 32'hDEAD_BEEF);
        @(negedge clk);
        chk("R6 first write landed LSB-first", rsp_rd_data, 32'h1122_3344);
        send(0, 0, 8'h09, 0, 6'd3, 6'd3, 32'h0);
        @(negedge clk);
        chk("R6 held request ignored", rsp_rd_data, 32'h1122_3344);
        chk("R7 ack cleared", {31'b0, rsp_wr_ack}, 32'h0);

        // R4: spare compare bits do nothing
        send(0, 0, 8'hE4, 0, 6'd0, 6'd3, 32'h0);
        @(negedge clk);
        chk("R4 spare bits ignored", {28'b0, cmp_en, cmp_clr}, 32'h0);

        // R2: reversed ordering, write and read back reg 15
        send(1, 1, 8'h12, 1, 6'd15, 6'd15, 32'hA5C3_0F81);
        send(1, 0, 8'h01, 0, 6'd15, 6'd15, 32'h0);
        @(negedge clk);
        chk("R2 reversed order readback", rsp_rd_data, 32'hA5C3_0F81);
        chk("R2 reversed stop", {31'b0, enc_stop}, 32'h0);

        // R9: boundary 16 and top 63, writes ignored
        send(0, 0, 8'h00, 1, 6'd16, 6'd16, 32'h7777_7777);
        @(negedge clk);
        chk("R9 abort at 16", {31'b0, rsp_rd_abort}, 32'h1);
        send(0, 0, 8'h00, 0, 6'd63, 6'd63, 32'h0);
        @(negedge clk);
        chk("R9 abort at 63 data", rsp_rd_data, 32'h0);
        send(0, 0, 8'h00, 1, 6'd63, 6'd0, 32'h5555_AAAA);
        @(negedge clk);
        chk("R9 implemented read no abort", {31'b0, rsp_rd_abort}, 32'h0);

        // R5: gating under each enable pattern
        send(0, 0, 8'h00, 0, 6'd0, 6'd0, 32'h0);
        @(posedge clk); #1 cmp_rel_raw = 2'b11; cmp_sts_raw = 2'b11; cmp_flag_raw = 2'b11;
        @(negedge clk);
        chk("R5 both disabled", {26'b0, cmp_rel, cmp_sts, cmp_flag}, 32'h0);
        send(0, 0, 8'h01, 0, 6'd0, 6'd0, 32'h0);
        @(negedge clk);
        chk("R5 only first enabled", {26'b0, cmp_rel, cmp_sts, cmp_flag}, 32'b010101);
        send(0, 0, 8'h08, 0, 6'd0, 6'd0, 32'h0);
        @(posedge clk); #1 cmp_sts_raw = 2'b01;
        @(negedge clk);
        chk("R5 only second enabled", {26'b0, cmp_rel, cmp_sts, cmp_flag}, 32'b100010);

        // R1: data changes without strobe leave everything alone
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1 tlg_data = {16{i[3:0]}} ^ 64'hFFFF_0000_FFFF_0000;
            order_rev = i[0];
        end
        @(negedge clk);
        chk("R1 no strobe no change", {28'b0, cmp_en, cmp_clr}, 32'b1000);

        // R10: reset clears the bank
        do_reset();
        send(0, 0, 8'h00, 0, 6'd0, 6'd3, 32'h0);
        @(negedge clk);
        chk("R10 bank cleared", rsp_rd_data, 32'h0);

        mon_on = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule